// File: doc/BRIEF.md
# Signed-Multiplicand Array Multiplier

This block multiplies a multiplicand by a multiplier in pure combinational logic. It is built as a row-by-row array of AND gates and full-adder cells rather than a behavioural multiply. Each multiplier bit gates a copy of the multiplicand, and that copy is shifted left by the bit's position. Each array row adds its gated copy into the running sum passed down from the row above. The low product bits leave the array one per row, from each row's rightmost column, and the last row supplies the upper bits.

A mode input selects how the multiplicand is read:

- **Unsigned mode:** the multiplicand is an unsigned magnitude.
- **Signed mode:** the multiplicand is a two's-complement number. Every gated copy is sign-extended across the full product width before it enters its row, so a negative multiplicand times a non-negative multiplier gives a correct two's-complement product.

In both modes the multiplier is always read as an unsigned magnitude. The product is two operand widths wide.

Top module: `amult_array`

## Requirements
- R1: With `signed_mode` = 0, `product` equals the unsigned product of `mcand` and `mplier`, exact over the full width for every operand pair.
- R2: With the default 4-bit operands in unsigned mode, `mcand` = 4'b1110 and `mplier` = 4'b1011 give `product` = 8'b10011010 (decimal 154).
- R3: With `signed_mode` = 1 and the sign bit (MSB) of `mcand` set, `product` equals the two's-complement value of `mcand` times the unsigned `mplier`, for every `mplier` whose MSB is clear. For example, with a 6-bit multiplicand and a 5-bit multiplier, -14 times +11 gives 11'h766 (-154).
- R4: With `signed_mode` = 1 and the MSB of `mcand` clear, `product` is the same as in unsigned mode, so the mode has no effect on non-negative multiplicands.
- R5: If either operand is zero, `product` is zero in both modes.
- R6: With `signed_mode` = 1 and the MSB of `mplier` set, `mplier` is still read as an unsigned magnitude. `product` equals the sign-extended `mcand` times the unsigned `mplier`, taken modulo 2^(`WM`+`WQ`).
- R7: With the default 4-bit operands, the largest values give the top of each range: 15 × 15 gives 8'hE1 in unsigned mode, and in signed mode -8 × 7 gives 8'hC8.
- R8: `product` follows any change on `mcand`, `mplier` or `signed_mode` in the same time step, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | WM | Multiplicand; two's complement when `signed_mode` is 1 |
| mplier | input | WQ | Multiplier, always an unsigned magnitude |
| signed_mode | input | 1 | 0 = unsigned multiplicand, 1 = sign-extended multiplicand |
| product | output | WM+WQ | Product of the two operands |

## Verification
Every result of this block is due in the same time step as its stimulus, zero clock cycles later, because no register lies between the operand inputs and `product`. The bench drives new operands on the falling edge of its pacing clock and samples `product` one nanosecond later. No rising edge falls between the drive and the sample, so each check sees exactly the settled response to the operands it applied. Expected values come from bench functions that extend the operands arithmetically, multiply, and truncate to the product width.

// File: rtl/amult_pkg.sv
// Package: amult_pkg
// Shared types for the array multiplier: the multiplicand interpretation mode.
// Assumes nothing beyond a 1-bit mode select at the block edge.
package amult_pkg;

    // How the multiplicand operand is interpreted.
    typedef enum logic {
        MUL_UNSIGNED = 1'b0,
        MUL_SIGNED_M = 1'b1
    } mul_mode_e;

endpackage

// File: rtl/amult_fa.sv
// Module: amult_fa
// One full-adder cell of the multiplier array.
// Assumes single-bit inputs; purely combinational.
module amult_fa (
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic s,
    output logic cout
);

    // Sum and majority carry of the three inputs.
    always_comb begin
        s    = a ^ b ^ cin;
        cout = (a & b) | (a & cin) | (b & cin);
    end

endmodule

// File: rtl/amult_pp.sv
// Module: amult_pp
// Forms one gated multiplicand copy for multiplier bit position J.
// Only the columns at or above J are produced (the columns below are zero
// and are not built). Bits above the multiplicand width are filled with the
// gated sign bit when sign_ext is set, or with zero otherwise.
// Assumes J < PW and WM >= 2.
module amult_pp #(
    parameter int WM = 4,
    parameter int PW = 8,
    parameter int J  = 0
) (
    input  logic [WM-1:0]   mcand,
    input  logic            q_bit,
    input  logic            sign_ext,
    output logic [PW-J-1:0] pp
);

    localparam int OW = PW - J;

    logic ext_bit;

    // Gated sign bit used for every column above the multiplicand.
    assign ext_bit = sign_ext & mcand[WM-1] & q_bit;

    genvar k;
    generate
        for (k = 0; k < OW; k++) begin : g_col
            if (k < WM) begin : g_and
                // AND gate for one multiplicand bit.
                assign pp[k] = mcand[k] & q_bit;
            end else begin : g_ext
                // Sign-extension column.
                assign pp[k] = ext_bit;
            end
        end
    endgenerate

endmodule

// File: rtl/amult_row.sv
// Module: amult_row
// One adder row of the array. It adds a gated multiplicand copy, which
// starts at column LSB, into the running sum from the row above. Columns
// below LSB pass straight through and are final product bits. The carry
// out of the top column is dropped, so the row works modulo 2^PW.
// Assumes 0 <= LSB <= PW-1.
module amult_row #(
    parameter int PW  = 8,
    parameter int LSB = 1
) (
    input  logic [PW-1:0]     acc_in,
    input  logic [PW-LSB-1:0] pp_in,
    output logic [PW-1:0]     acc_out
);

    logic [PW-1:LSB] carry;

    // Rightmost column of the row has no incoming carry.
    assign carry[LSB] = 1'b0;

    genvar c;
    generate
        for (c = 0; c < LSB; c++) begin : g_pass
            // Settled product bits pass through unchanged.
            assign acc_out[c] = acc_in[c];
        end
        for (c = LSB; c < PW - 1; c++) begin : g_cell
            // Full-adder cell for one column of the row.
            amult_fa u_fa (
                .a    (acc_in[c]),
                .b    (pp_in[c-LSB]),
                .cin  (carry[c]),
                .s    (acc_out[c]),
                .cout (carry[c+1])
            );
        end
    endgenerate

    // Top column keeps only the sum; its carry lies beyond the product width.
    assign acc_out[PW-1] = acc_in[PW-1] ^ pp_in[PW-1-LSB] ^ carry[PW-1];

endmodule

// File: rtl/amult_array.sv
// Module: amult_array
// Combinational WM x WQ array multiplier. Row 0 is the gated copy for
// multiplier bit 0. Each later row j adds the copy for bit j, shifted by j,
// into the row above. In signed mode every copy is sign-extended to the
// full product width, so a negative multiplicand gives a correct
// two's-complement product. The multiplier is always unsigned.
// Assumes WM >= 2 and WQ >= 2. No clock, no reset, no state.
module amult_array #(
    parameter int WM = 4,
    parameter int WQ = 4
) (
    input  logic [WM-1:0]    mcand,
    input  logic [WQ-1:0]    mplier,
    input  logic             signed_mode,
    output logic [WM+WQ-1:0] product
);

    import amult_pkg::*;

    localparam int PW = WM + WQ;

    mul_mode_e mode;
    logic      sign_ext;
    logic [PW-1:0] acc [WQ];

    // Decode the mode input into the sign-extension enable.
    always_comb begin
        mode     = mul_mode_e'(signed_mode);
        sign_ext = (mode == MUL_SIGNED_M);
    end

    // Row 0: gated copy for multiplier bit 0 seeds the running sum.
    amult_pp #(.WM(WM), .PW(PW), .J(0)) u_pp0 (
        .mcand    (mcand),
        .q_bit    (mplier[0]),
        .sign_ext (sign_ext),
        .pp       (acc[0])
    );

    genvar j;
    generate
        for (j = 1; j < WQ; j++) begin : g_row
            logic [PW-j-1:0] pp_j;

            // Gated, shifted copy for multiplier bit j.
            amult_pp #(.WM(WM), .PW(PW), .J(j)) u_pp (
                .mcand    (mcand),
                .q_bit    (mplier[j]),
                .sign_ext (sign_ext),
                .pp       (pp_j)
            );

            // Add that copy into the sum from the row above.
            amult_row #(.PW(PW), .LSB(j)) u_row (
                .acc_in  (acc[j-1]),
                .pp_in   (pp_j),
                .acc_out (acc[j])
            );
        end
    endgenerate

    // The last row holds the complete product.
    assign product = acc[WQ-1];

endmodule

// File: rtl/amult_chk.sv
// Module: amult_chk
// Assertion checker for amult_array, attached by bind. It compares the
// array's output with arithmetic products formed from the operand ports.
// Assumes the same WM/WQ as the bound instance.
module amult_chk #(
    parameter int WM = 4,
    parameter int WQ = 4
) (
    input logic [WM-1:0]    mcand,
    input logic [WQ-1:0]    mplier,
    input logic             signed_mode,
    input logic [WM+WQ-1:0] product
);

    localparam int PW = WM + WQ;

    logic [PW-1:0] m_zext;
    logic [PW-1:0] m_sext;
    logic [PW-1:0] q_zext;
    logic [PW-1:0] u_ref;
    logic [PW-1:0] s_ref;

    // Reference products from the operand ports.
    always_comb begin
        m_zext = {{WQ{1'b0}}, mcand};
        m_sext = {{WQ{mcand[WM-1]}}, mcand};
        q_zext = {{WM{1'b0}}, mplier};
        u_ref  = m_zext * q_zext;
        s_ref  = m_sext * q_zext;
    end

    // Output checks against the references, once per settled evaluation.
    always_comb begin
        p_unsigned_exact_r1: assert (signed_mode || product == u_ref)
            else $error("unsigned product mismatch");
        p_neg_mcand_r3: assert (!(signed_mode && mcand[WM-1] && !mplier[WQ-1]) || product == s_ref)
            else $error("negative multiplicand product mismatch");
        p_mode_no_effect_r4: assert (!(signed_mode && !mcand[WM-1]) || product == u_ref)
            else $error("mode changed a non-negative product");
        p_zero_operand_r5: assert (!(mcand == '0 || mplier == '0) || product == '0)
            else $error("zero operand gave non-zero product");
        p_mplier_magnitude_r6: assert (!(signed_mode && mplier[WQ-1]) || product == s_ref)
            else $error("multiplier not read as magnitude");
    end

endmodule

bind amult_array amult_chk #(.WM(WM), .WQ(WQ)) u_chk (
    .mcand       (mcand),
    .mplier      (mplier),
    .signed_mode (signed_mode),
    .product     (product)
);

// File: tb/sim_amult_array.sv
module sim_amult_array;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // 4x4 default instance
    logic [3:0] m4, q4;
    logic       s4;
    logic [7:0] p4;
    // 6x5 instance for wider signed checks
    logic [5:0]  m6;
    logic [4:0]  q5;
    logic        s6;
    logic [10:0] p11;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    amult_array u0 (.mcand(m4), .mplier(q4), .signed_mode(s4), .product(p4));
    amult_array #(.WM(6), .WQ(5)) u1 (.mcand(m6), .mplier(q5), .signed_mode(s6), .product(p11));

    function automatic logic [7:0] ref4(logic [3:0] m, logic [3:0] q, logic s);
        logic [7:0] me;
        me = s ? {{4{m[3]}}, m} : {4'b0, m};
        return me * {4'b0, q};
    endfunction

    function automatic logic [10:0] ref11(logic [5:0] m, logic [4:0] q, logic s);
        logic [10:0] me;
        me = s ? {{5{m[5]}}, m} : {5'b0, m};
        return me * {6'b0, q};
    endfunction

    task automatic chk4(logic [3:0] m, logic [3:0] q, logic s, logic [7:0] exp, string req);
        @(negedge clk);
        m4 = m; q4 = q; s4 = s;
        #1;
        n_vec++;
        if (p4 !== exp) begin
            n_bad++;
            $display("FAIL %s: m=%h q=%h s=%0d actual=%h expected=%h", req, m, q, s, p4, exp);
        end
    endtask

    task automatic chk11(logic [5:0] m, logic [4:0] q, logic s, logic [10:0] exp, string req);
        @(negedge clk);
        m6 = m; q5 = q; s6 = s;
        #1;
        n_vec++;
        if (p11 !== exp) begin
            n_bad++;
            $display("FAIL %s: m=%h q=%h s=%0d actual=%h expected=%h", req, m, q, s, p11, exp);
        end
    endtask

    initial begin
        m4 = '0; q4 = '0; s4 = 1'b0;
        m6 = '0; q5 = '0; s6 = 1'b0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Initial state: zero operands give zero (R5)
        #1;
        n_vec++;
        if (p4 !== 8'h00) begin
            n_bad++;
            $display("FAIL R5: initial actual=%h expected=00", p4);
        end

        // Directed corners
        chk4(4'b1110, 4'b1011, 1'b0, 8'b10011010, "R2");
        chk11(6'b110010, 5'b01011, 1'b1, 11'h766, "R3");
        chk4(4'hF, 4'hF, 1'b0, 8'hE1, "R7");
        chk4(4'h8, 4'h7, 1'b1, 8'hC8, "R7");
        chk4(4'h0, 4'hF, 1'b1, 8'h00, "R5");
        chk4(4'hF, 4'h0, 1'b1, 8'h00, "R5");

        // Exhaustive unsigned mode (R1)
        for (int m = 0; m < 16; m++)
            for (int q = 0; q < 16; q++)
                chk4(4'(m), 4'(q), 1'b0, 8'(m * q), "R1");

        // Signed mode, non-negative multiplier: R3 for negative M, R4 otherwise
        for (int m = 0; m < 16; m++)
            for (int q = 0; q < 8; q++)
                chk4(4'(m), 4'(q), 1'b1, ref4(4'(m), 4'(q), 1'b1), (m >= 8) ? "R3" : "R4");

        // Signed mode, multiplier MSB set: magnitude reading (R6)
        for (int m = 0; m < 16; m++)
            for (int q = 8; q < 16; q++)
                chk4(4'(m), 4'(q), 1'b1, ref4(4'(m), 4'(q), 1'b1), "R6");

        // Same-step response to a mode flip only (R8)
        chk4(4'hA, 4'h3, 1'b0, 8'h1E, "R8");
        chk4(4'hA, 4'h3, 1'b1, 8'hEE, "R8");

        // Random vectors on the wider instance (R1/R3/R6)
        for (int i = 0; i < 300; i++) begin
            logic [5:0] rm;
            logic [4:0] rq;
            logic       rs;
            rm = 6'($urandom);
            rq = 5'($urandom);
            rs = 1'($urandom);
            chk11(rm, rq, rs, ref11(rm, rq, rs), rs ? "R3_R6" : "R1");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule